// File: doc/BRIEF.md
# Receive Sampling Delay Sweep Controller

This block searches for a usable receive sampling delay on a card interface. Starting at code zero, it steps a delay code upward one value at a time. For each code it drives the code onto a delay output and runs one trial through a start/done/pass handshake with an external trial engine. It records the first code that passes. The sweep ends at the first failing trial after that point, or after the highest code. If a trial engine never answers, a programmable timeout counts the trial as a failure.

After the sweep, the controller computes a chosen delay from the window start and the stop index, and applies it. It then runs one confirming trial at that delay. It finishes with a one-cycle done pulse, an error flag and the final code. The delay code also appears in a 32-bit control word at a fixed field. The word's repeat-count field is forced to zero, and its other bits come from a configuration word captured at launch. Issuing card commands, the delay line itself and comparing the received data belong to other blocks.

Top module: `dly_sweep_ctrl`

## Requirements
- R1: After reset, trial_start_o, done_o, busy_o and err_o are 0, and delay_o and final_code_o are 0.
- R2: A sweep runs one trial per code, in increasing order from 0. delay_o holds the trial's code for at least one cycle before trial_start_o rises. trial_start_o is a single-cycle pulse.
- R3: The first code whose trial passes becomes the window start. Later passing trials do not change it.
- R4: Once a window start exists, the first failing trial ends the sweep at once, and that code becomes the stop index. No further sweep trials are started.
- R5: If no trial fails after the window start, the sweep covers all 32 codes and the stop index is 32.
- R6: With a window, the chosen delay is (window start + stop index) / 4, truncated.
- R7: If trial_done_i does not arrive within tmo_limit_i + 1 cycles after the start pulse, the trial counts as a failure.
- R8: If no sweep trial passes, the chosen delay is 0 and err_o is 1.
- R9: Exactly one confirming trial runs at the chosen delay. Then done_o pulses for one cycle, and final_code_o holds the chosen delay. err_o is 1 when there was no window or the confirming trial failed, and 0 otherwise. err_o and final_code_o hold until the next launch.
- R10: ctrl_word_o has the delay code in bits 20:16 and zeros in bits 28:24. Every other bit equals the cfg_word_i value captured when the sweep was launched.
- R11: go_i is ignored while busy_o is 1. The running sweep, its configuration word and its result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Launch a sweep (used only when idle) |
| cfg_word_i | input | 32 | Control word base, captured at launch |
| tmo_limit_i | input | 16 | Trial timeout limit in cycles |
| trial_start_o | output | 1 | One-cycle trial start pulse |
| trial_done_i | input | 1 | Trial finished |
| trial_pass_i | input | 1 | Trial result, valid with trial_done_i |
| delay_o | output | 5 | Current sampling delay code |
| ctrl_word_o | output | 32 | Control word with the delay field inserted |
| busy_o | output | 1 | Sweep or confirmation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Tuning failed |
| final_code_o | output | 5 | Delay code chosen by the last sweep |

## Verification
The hardest situations to reach are a trial engine that goes silent in the middle of a passing window, and a launch request that arrives during a running sweep. The bench's trial responder reads a per-code pass map and a per-code silent map. The silent map lets a timeout split a window at a chosen code. A directed case pulses go_i with a different configuration word mid-sweep. Random windows with scattered passes after their end show that the sweep stops at the first failure and keeps the first window start.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_CALC, S_CONF_ISSUE, S_CONF_WAIT
  } sweep_state_e;

  typedef enum logic [1:0] {
    T_IDLE, T_SETUP, T_WAIT
  } trial_state_e;
endpackage

// File: rtl/dsw_trial_runner.sv
module dsw_trial_runner
  import dsw_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             done_i,
  input  logic             pass_i,
  output logic             start_o,
  output logic             res_valid_o,
  output logic             res_pass_o
);
  trial_state_e     ts;
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts          <= T_IDLE;
      start_o     <= 1'b0;
      cnt         <= '0;
      res_valid_o <= 1'b0;
      res_pass_o  <= 1'b0;
    end else begin
      start_o     <= 1'b0;
      res_valid_o <= 1'b0;
      case (ts)
        T_IDLE: if (req_i) ts <= T_SETUP;
        T_SETUP: begin
          start_o <= 1'b1;
          cnt     <= '0;
          ts      <= T_WAIT;
        end
        T_WAIT: begin
          if (done_i) begin
            res_valid_o <= 1'b1;
            res_pass_o  <= pass_i;
            ts          <= T_IDLE;
          end else if (cnt >= tmo_limit_i) begin
            res_valid_o <= 1'b1;
            res_pass_o  <= 1'b0;
            ts          <= T_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ts <= T_IDLE;
      endcase
    end
  end

  // R2: start is a single-cycle pulse
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  // R7: a result reported without a done input is a failure
  a_r7_timeout_fail: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && !$past(done_i)) |-> !res_pass_o);
endmodule

// File: rtl/dsw_window_tracker.sv
module dsw_window_tracker #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic              pass_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              have_o,
  output logic [CODE_W-1:0] start_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      have_o  <= 1'b0;
      start_o <= '0;
    end else if (upd_i && pass_i && !have_o) begin
      have_o  <= 1'b1;
      start_o <= code_i;
    end
  end

  // R3: once latched, the window start does not move until cleared
  a_r3_start_hold: assert property (@(posedge clk) disable iff (rst)
    (have_o && !clr_i) |=> (have_o && $stable(start_o)));
endmodule

// File: rtl/dsw_delay_pick.sv
module dsw_delay_pick #(
  parameter int CODE_W = 5
) (
  input  logic              have_i,
  input  logic [CODE_W-1:0] start_i,
  input  logic [CODE_W:0]   stop_i,
  output logic [CODE_W-1:0] pick_o
);
  logic [CODE_W:0] sum;

  always_comb begin
    sum    = {1'b0, start_i} + stop_i;
    pick_o = have_i ? {1'b0, sum[CODE_W:2]} : '0;
  end
endmodule

// File: rtl/dly_sweep_ctrl.sv
module dly_sweep_ctrl
  import dsw_pkg::*;
#(
  parameter int CODE_W  = 5,
  parameter int TMO_W   = 16,
  parameter int WORD_W  = 32,
  parameter int DLY_LSB = 16,
  parameter int RPT_LSB = 24,
  parameter int RPT_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output logic              trial_start_o,
  input  logic              trial_done_i,
  input  logic              trial_pass_i,
  output logic [CODE_W-1:0] delay_o,
  output logic [WORD_W-1:0] ctrl_word_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CODE_W-1:0] final_code_o
);
  localparam int NCODES = 1 << CODE_W;
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NCODES - 1);
  localparam logic [CODE_W:0]   STOP_ALL = (CODE_W+1)'(NCODES);

  sweep_state_e      st;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] delay_q;
  logic [CODE_W:0]   stop_q;
  logic [WORD_W-1:0] cfg_q;
  logic              req;
  logic              res_valid, res_pass;
  logic              have_win;
  logic [CODE_W-1:0] win_start;
  logic [CODE_W-1:0] pick;
  logic              launch;

  assign req    = (st == S_ISSUE) || (st == S_CONF_ISSUE);
  assign launch = (st == S_IDLE) && go_i;

  dsw_trial_runner #(.TMO_W(TMO_W)) u_trial (
    .clk(clk), .rst(rst), .req_i(req), .tmo_limit_i(tmo_limit_i),
    .done_i(trial_done_i), .pass_i(trial_pass_i), .start_o(trial_start_o),
    .res_valid_o(res_valid), .res_pass_o(res_pass)
  );

  dsw_window_tracker #(.CODE_W(CODE_W)) u_win (
    .clk(clk), .rst(rst), .clr_i(launch),
    .upd_i(res_valid && (st == S_WAIT)), .pass_i(res_pass),
    .code_i(code_q), .have_o(have_win), .start_o(win_start)
  );

  dsw_delay_pick #(.CODE_W(CODE_W)) u_pick (
    .have_i(have_win), .start_i(win_start), .stop_i(stop_q), .pick_o(pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      code_q       <= '0;
      delay_q      <= '0;
      stop_q       <= '0;
      cfg_q        <= '0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      final_code_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (go_i) begin
          cfg_q   <= cfg_word_i;
          code_q  <= '0;
          delay_q <= '0;
          err_o   <= 1'b0;
          st      <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (res_valid) begin
          if (!res_pass && have_win) begin
            stop_q <= {1'b0, code_q};
            st     <= S_CALC;
          end else if (code_q == MAX_CODE) begin
            stop_q <= STOP_ALL;
            st     <= S_CALC;
          end else begin
            code_q  <= code_q + 1'b1;
            delay_q <= code_q + 1'b1;
            st      <= S_ISSUE;
          end
        end
        S_CALC: begin
          delay_q <= pick;
          st      <= S_CONF_ISSUE;
        end
        S_CONF_ISSUE: st <= S_CONF_WAIT;
        S_CONF_WAIT: if (res_valid) begin
          err_o        <= !have_win || !res_pass;
          final_code_o <= delay_q;
          done_o       <= 1'b1;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign delay_o = delay_q;
  assign busy_o  = (st != S_IDLE);

  always_comb begin
    ctrl_word_o = cfg_q;
    ctrl_word_o[RPT_LSB +: RPT_W]  = '0;
    ctrl_word_o[DLY_LSB +: CODE_W] = delay_q;
  end

  // R2: delay is settled before a trial starts
  a_r2_delay_stable: assert property (@(posedge clk) disable iff (rst)
    $rose(trial_start_o) |-> $stable(delay_o));
  // R2: successive sweep trials step the code by one
  a_r2_code_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_ISSUE && $past(st) == S_WAIT) |-> (delay_o == $past(delay_o) + 1'b1));
  // R9: done is a single-cycle pulse and leaves the block idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o ##1 !done_o));
  // R11: a go while busy does not restart the sweep
  a_r11_go_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_o && go_i && st == S_WAIT) |=> (st != S_ISSUE || delay_o != '0));
endmodule

// File: tb/sim_dly_sweep_ctrl.sv
module sim_dly_sweep_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic        go = 0;
  logic [31:0] cfg = 0;
  logic [15:0] tmo = 16'd20;
  logic        tstart, tdone = 0, tpass = 0;
  logic [4:0]  delay, fcode;
  logic [31:0] cword;
  logic        busy, done, err;

  int checks = 0, errors = 0;
  logic [31:0] pass_map = 0, silent_map = 0;
  int trial_cnt = 0;
  int exp_code = 0, exp_sweep = 0;
  bit exp_err = 0;

  always #5 clk = ~clk;

  dly_sweep_ctrl u0 (
    .clk(clk), .rst(rst), .go_i(go), .cfg_word_i(cfg), .tmo_limit_i(tmo),
    .trial_start_o(tstart), .trial_done_i(tdone), .trial_pass_i(tpass),
    .delay_o(delay), .ctrl_word_o(cword), .busy_o(busy), .done_o(done),
    .err_o(err), .final_code_o(fcode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic bit good(input int c);
    return pass_map[c] && !silent_map[c];
  endfunction

  // Expected outcome from the requirements (R3-R9)
  task automatic predict();
    int first = -1;
    int stop = 32;
    for (int i = 0; i < 32; i++) begin
      if (good(i) && first < 0) first = i;
      else if (!good(i) && first >= 0) begin stop = i; break; end
    end
    exp_sweep = (first >= 0 && stop < 32) ? stop + 1 : 32;
    exp_code  = (first < 0) ? 0 : (first + stop) / 4;
    exp_err   = (first < 0) || !good(exp_code);
  endtask

  // Trial engine model; checks the code of each trial (R2)
  initial begin
    forever begin
      @(negedge clk);
      if (tstart) begin
        automatic int c = delay;
        automatic int expc = (trial_cnt < exp_sweep) ? trial_cnt : exp_code;
        chk(c == expc, "R2 trial code", c, expc);
        trial_cnt++;
        if (!silent_map[c]) begin
          repeat (1 + $urandom % 8) @(negedge clk);
          tdone = 1; tpass = pass_map[c];
          @(negedge clk);
          tdone = 0; tpass = 0;
        end
      end
    end
  end

  task automatic run(input logic [31:0] pm, input logic [31:0] sm,
                     input logic [31:0] cw, input bit poke);
    int n = 0;
    pass_map = pm; silent_map = sm;
    predict();
    trial_cnt = 0;
    @(negedge clk); cfg = cw; go = 1;
    @(negedge clk); go = 0; cfg = ~cw;
    while (!done && n < 3000) begin
      @(negedge clk); n++;
      if (poke && n == 40) go = 1;
      if (poke && n == 41) go = 0;
    end
    chk(done == 1, "R9 done seen", done, 1);
    chk(fcode == exp_code, "R6 R8 final code", fcode, exp_code);
    chk(err == exp_err, "R8 R9 error flag", err, exp_err);
    chk(trial_cnt == exp_sweep + 1, "R4 R5 trial count", trial_cnt, exp_sweep + 1);
    chk(cword == ((cw & ~32'h1F1F_0000) | (32'(exp_code) << 16)),
        "R10 control word", cword, (cw & ~32'h1F1F_0000) | (32'(exp_code) << 16));
    @(negedge clk);
    chk(!done && !busy, "R9 done pulse", {done, busy}, 0);
    chk(fcode == exp_code && err == exp_err, "R9 result held", fcode, exp_code);
  endtask

  function automatic logic [31:0] win(input int lo, input int hi);
    logic [31:0] m = 0;
    for (int i = lo; i <= hi && i < 32; i++) m[i] = 1;
    return m;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!tstart && !done && !busy && !err, "R1 reset flags", {tstart, done, busy, err}, 0);
    chk(delay == 0 && fcode == 0, "R1 reset codes", {delay, fcode}, 0);
    // R8 no pass at all
    run(32'h0, 32'h0, 32'hFFFF_FFFF, 0);
    // R5 all pass: (0+32)/4 = 8
    run(32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 0);
    // R5 R6 only last code passes: (31+32)/4 = 15, confirm fails
    run(32'h8000_0000, 32'h0, 32'h1234_5678, 0);
    // R4 window 0..9: stop 10, pick 2, confirm passes
    run(win(0, 9), 32'h0, 32'h0, 0);
    // R3 R4 window 4..10 with later passes: pick 3, confirm fails
    run(win(4, 10) | win(20, 25), 32'h0, 32'hDEAD_BEEF, 0);
    // R7 silent trial inside window 2..12 at code 8: pick 2
    run(win(2, 12), 32'h0000_0100, 32'h0F0F_0F0F, 0);
    // R11 go pulse mid-sweep
    run(win(6, 20), 32'h0, 32'h5555_AAAA, 1);
    // random windows with scattered passes and occasional silence
    for (int k = 0; k < 30; k++) begin
      automatic int lo = $urandom % 32;
      automatic logic [31:0] pm = win(lo, lo + $urandom % 14) | ($urandom & $urandom);
      automatic logic [31:0] sm = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      run(pm, sm, $urandom, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule